// File: doc/BRIEF.md
# Reconfigurable PWM and Capture Timer Slice

This block is one slice of a multi-slice timer unit; the unit places several identical copies side by side. One set of counting hardware, two 8-bit halves, is reconfigured by a mode field. It can act as two unrelated 8-bit pulse-width generators or as one 16-bit pulse-width generator made by chaining the halves. It can also act as a free-running 16-bit counter whose value two input pins can latch. A private prescaler sets the rate at which the slice counts.

Software programs the slice through a small write port and reads it back through a read port with registered data. The block drives two waveform outputs and two capture interrupt flags. Period and duty values are held in shadow registers. They reach the comparators only at a period boundary or on a mode change, so a waveform never shows a partly updated cycle.

Top module: `vt_subsys`

## Requirements
- R1: After reset every readable register (addresses 0x0 to 0xA) reads 0, both waveform outputs are low and both interrupt outputs are low.
- R2: The prescaler (address 0x1) advances the counters once every (value + 1) clocks, so 0 counts on every clock.
- R3: In mode 0 (CTRL address 0x0, bits [1:0] = 0), channel k counts 0..PERk and restarts. PER0/PER1 are at 0x2/0x3 and DUTY0/DUTY1 at 0x4/0x5. Output k is high while the count is below DUTYk, so each period has min(DUTY, PER+1) high ticks out of PER+1.
- R4: In mode 0 the two channels run independently, each with its own period and duty.
- R5: In mode 1 the halves form one 16-bit counter. PER1:PER0 and DUTY1:DUTY0 are the high:low bytes of the 16-bit period and duty, output 0 follows the R3 rule on 16 bits, and output 1 stays low.
- R6: Writes to period or duty registers take effect only at the next period boundary or mode change.
- R7: In mode 2 the 16-bit counter runs freely. An edge on cap_i[k] of the polarity chosen by CTRL bit 2+k (0 rising, 1 falling) latches the counter into CAPk: CAP0 low/high at 0x6/0x7, CAP1 at 0x8/0x9. The edge also sets status bit k (address 0xA) and irq_o[k]. The input passes two synchronizer stages, so an edge driven after the clock that leaves the count at n latches n+2. Edges in other modes are ignored.
- R8: A capture on channel k while its status bit k is still set sets overrun status bit 2+k.
- R9: Writing 1 to a status bit clears it; writing 0 leaves it.
- R10: A write to CTRL that changes the mode clears both counters, the prescaler and both outputs on the next clock. Mode 3 holds the counters at zero with outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data, one clock after rd_addr |
| cap_i | input | 2 | Capture pins, asynchronous |
| pwm_o | output | 2 | Waveform outputs, registered |
| irq_o | output | 2 | Capture flags |

## Verification
The assertions take it that a period register only reaches the comparator through a boundary reload or a mode change. Under that assumption the count never exceeds the active period. They also take it that capture pins change no faster than the synchronizer can resolve an edge. The bench therefore changes modes only through an idle step, programs shadows before leaving idle, and holds each capture level for many clocks. It never clears a flag in the same clock as an edge.

// File: rtl/vt_pkg.sv
package vt_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    MD_DUAL8  = 2'd0,
    MD_WIDE16 = 2'd1,
    MD_CAPT   = 2'd2,
    MD_IDLE   = 2'd3
  } vt_mode_e;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] A_PRESC = 4'h1;
  localparam logic [ADDR_W-1:0] A_PER0  = 4'h2;
  localparam logic [ADDR_W-1:0] A_PER1  = 4'h3;
  localparam logic [ADDR_W-1:0] A_DUTY0 = 4'h4;
  localparam logic [ADDR_W-1:0] A_DUTY1 = 4'h5;
  localparam logic [ADDR_W-1:0] A_CAP0L = 4'h6;
  localparam logic [ADDR_W-1:0] A_CAP0H = 4'h7;
  localparam logic [ADDR_W-1:0] A_CAP1L = 4'h8;
  localparam logic [ADDR_W-1:0] A_CAP1H = 4'h9;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'hA;
endpackage

// File: rtl/vt_prescaler.sv
module vt_prescaler #(
  parameter int PSW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic [PSW-1:0] div_i,
  output logic           tick_o
);
  logic [PSW-1:0] phase;

  assign tick_o = !clr && (phase >= div_i);

  always_ff @(posedge clk) begin
    if (rst || clr)          phase <= '0;
    else if (phase >= div_i) phase <= '0;
    else                     phase <= phase + 1'b1;
  end

  // R2: after a tick the next one needs a full (div+1) wait unless div is 0
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/vt_count_half.sv
module vt_count_half #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt_o <= '0;
    else if (inc)   cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/vt_capture.sv
module vt_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         arm,
  input  logic         fall_sel,
  input  logic         pin_i,
  input  logic [W-1:0] cnt_i,
  input  logic         clr_flag,
  input  logic         clr_ovr,
  output logic [W-1:0] val_o,
  output logic         flag_o,
  output logic         ovr_o
);
  logic s1, s2, s3, edge_seen, evt;

  always_ff @(posedge clk) begin
    if (rst) {s1, s2, s3} <= '0;
    else     {s1, s2, s3} <= {pin_i, s1, s2};
  end

  assign edge_seen = fall_sel ? (s3 & ~s2) : (s2 & ~s3);
  assign evt       = arm & edge_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_o  <= '0;
      flag_o <= 1'b0;
      ovr_o  <= 1'b0;
    end else begin
      if (evt) val_o <= cnt_i;
      if (evt)           flag_o <= 1'b1;
      else if (clr_flag) flag_o <= 1'b0;
      if (evt && flag_o) ovr_o <= 1'b1;
      else if (clr_ovr)  ovr_o <= 1'b0;
    end
  end

  // R8: overrun only rises when a capture was already pending
  assert_ovr_pending_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_o) |-> $past(flag_o));
  // R7: the flag only rises while capture is armed
  assert_flag_armed_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(arm));
endmodule

// File: rtl/vt_subsys.sv
module vt_subsys
  import vt_pkg::*;
#(
  parameter int HW  = 8,
  parameter int PSW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [HW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [HW-1:0]     rd_data,
  input  logic [1:0]        cap_i,
  output logic [1:0]        pwm_o,
  output logic [1:0]        irq_o
);
  localparam int FW = 2 * HW;

  vt_mode_e           mode_q;
  logic [1:0]         fall_q;
  logic [PSW-1:0]     presc_q;
  logic [1:0][HW-1:0] per_sh, duty_sh, per_act, duty_act, cnt;
  logic [1:0]         inc, clr, wrap, load;
  logic [1:0]         cflag, covr;
  logic [1:0][FW-1:0] cval;
  logic               mode_chg, tick, sts_wr;
  logic [FW-1:0]      cnt16, per16, duty16;

  assign mode_chg = wr_en && (wr_addr == A_CTRL) && (wr_data[1:0] != mode_q);
  assign sts_wr   = wr_en && (wr_addr == A_STAT);
  assign cnt16    = {cnt[1], cnt[0]};
  assign per16    = {per_act[1], per_act[0]};
  assign duty16   = {duty_act[1], duty_act[0]};

  // configuration and shadow registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MD_DUAL8;
      fall_q  <= '0;
      presc_q <= '0;
      per_sh  <= '0;
      duty_sh <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          mode_q <= vt_mode_e'(wr_data[1:0]);
          fall_q <= wr_data[3:2];
        end
        A_PRESC: presc_q    <= wr_data[PSW-1:0];
        A_PER0:  per_sh[0]  <= wr_data;
        A_PER1:  per_sh[1]  <= wr_data;
        A_DUTY0: duty_sh[0] <= wr_data;
        A_DUTY1: duty_sh[1] <= wr_data;
        default: ;
      endcase
    end
  end

  vt_prescaler #(.PSW(PSW)) u_psc (
    .clk(clk), .rst(rst), .clr(mode_chg), .div_i(presc_q), .tick_o(tick)
  );

  // counter sequencing per mode
  always_comb begin
    inc  = '0;
    wrap = '0;
    case (mode_q)
      MD_DUAL8: begin
        inc     = {tick, tick};
        wrap[0] = tick && (cnt[0] == per_act[0]);
        wrap[1] = tick && (cnt[1] == per_act[1]);
      end
      MD_WIDE16: begin
        inc  = {tick && (&cnt[0]), tick};
        wrap = {2{tick && (cnt16 == per16)}};
      end
      MD_CAPT: inc = {tick && (&cnt[0]), tick};
      default: ;
    endcase
    clr  = wrap | {2{mode_chg || (mode_q == MD_IDLE)}};
    load = wrap | {2{mode_chg || (mode_q == MD_CAPT) || (mode_q == MD_IDLE)}};
  end

  for (genvar g = 0; g < 2; g++) begin : g_half
    vt_count_half #(.W(HW)) u_half (
      .clk(clk), .rst(rst), .clr(clr[g]), .inc(inc[g]), .cnt_o(cnt[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        per_act[g]  <= '0;
        duty_act[g] <= '0;
      end else if (load[g]) begin
        per_act[g]  <= per_sh[g];
        duty_act[g] <= duty_sh[g];
      end
    end

    vt_capture #(.W(FW)) u_cap (
      .clk(clk), .rst(rst),
      .arm(mode_q == MD_CAPT && !mode_chg),
      .fall_sel(fall_q[g]), .pin_i(cap_i[g]), .cnt_i(cnt16),
      .clr_flag(sts_wr && wr_data[g]), .clr_ovr(sts_wr && wr_data[2+g]),
      .val_o(cval[g]), .flag_o(cflag[g]), .ovr_o(covr[g])
    );
  end

  // registered waveform outputs
  always_ff @(posedge clk) begin
    if (rst || mode_chg) pwm_o <= '0;
    else begin
      case (mode_q)
        MD_DUAL8:  pwm_o <= {cnt[1] < duty_act[1], cnt[0] < duty_act[0]};
        MD_WIDE16: pwm_o <= {1'b0, cnt16 < duty16};
        default:   pwm_o <= '0;
      endcase
    end
  end

  assign irq_o = cflag;

  // read port
  logic [HW-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (rd_addr)
      A_CTRL:  rd_next[3:0]     = {fall_q, mode_q};
      A_PRESC: rd_next[PSW-1:0] = presc_q;
      A_PER0:  rd_next = per_sh[0];
      A_PER1:  rd_next = per_sh[1];
      A_DUTY0: rd_next = duty_sh[0];
      A_DUTY1: rd_next = duty_sh[1];
      A_CAP0L: rd_next = cval[0][HW-1:0];
      A_CAP0H: rd_next = cval[0][FW-1:HW];
      A_CAP1L: rd_next = cval[1][HW-1:0];
      A_CAP1H: rd_next = cval[1][FW-1:HW];
      A_STAT:  rd_next[3:0] = {covr, cflag};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  // R3: in dual mode neither half runs past its active period
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_DUAL8) |-> (cnt[0] <= per_act[0] && cnt[1] <= per_act[1]));
  // R10: a mode change leaves counters and outputs at zero
  assert_mode_clear_R10: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (pwm_o == 2'b00 && cnt16 == '0));
  // R5: second output is silent in chained mode
  assert_wide_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_WIDE16 && $past(mode_q) == MD_WIDE16) |-> !pwm_o[1]);
endmodule

// File: tb/sim_vt_subsys.sv
module sim_vt_subsys;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] cap_i = '0;
  logic [1:0] pwm_o, irq_o;

  int vectors = 0, miscompares = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(negedge clk) cyc++;

  vt_subsys u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cap_i(cap_i), .pwm_o(pwm_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); rd_addr = 4'(a);
    @(negedge clk); d = int'(rd_data);
  endtask

  task automatic rd16(input int a, output int d);
    int lo, hi;
    rd(a, lo); rd(a + 1, hi);
    d = hi * 256 + lo;
  endtask

  task automatic measure(input int n, output int h0, output int h1);
    h0 = 0; h1 = 0;
    repeat (n) begin
      @(negedge clk);
      h0 += int'(pwm_o[0]);
      h1 += int'(pwm_o[1]);
    end
  endtask

  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic setup(input int mode, input int ps, input int p0, input int p1,
                       input int d0, input int d1);
    wr(0, 3);
    wr(1, ps); wr(2, p0); wr(3, p1); wr(4, d0); wr(5, d1);
    wr(0, mode);
  endtask

  initial begin
    int v, h0, h1, c1, c2, t1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a <= 10; a++) begin
      rd(a, v);
      chk($sformatf("R1 reg %0d", a), v, 0);
    end
    chk("R1 pwm", int'(pwm_o), 0);
    chk("R1 irq", int'(irq_o), 0);

    // R3 R4 R2: dual 8-bit sweep, two prescaler settings
    for (int ps = 0; ps <= 2; ps += 2)
      for (int p0 = 0; p0 < 6; p0++)
        for (int d0 = 0; d0 <= p0 + 2; d0++) begin
          int p1, d1, win;
          p1 = 7 - p0; d1 = p0;
          setup(0, ps, p0, p1, d0, d1);
          repeat (4) @(negedge clk);
          win = (p0 + 1) * (p1 + 1) * (ps + 1);
          measure(win, h0, h1);
          chk($sformatf("R3 R2 ch0 ps=%0d per=%0d duty=%0d", ps, p0, d0), h0,
              (p1 + 1) * mn(d0, p0 + 1) * (ps + 1));
          chk($sformatf("R4 ch1 ps=%0d per=%0d duty=%0d", ps, p1, d1), h1,
              (p0 + 1) * mn(d1, p1 + 1) * (ps + 1));
        end

    // R5: chained 16-bit generator
    for (int ps = 0; ps <= 1; ps++)
      for (int pi = 0; pi < 2; pi++)
        for (int di = 0; di < 7; di++) begin
          int per, duty, win;
          per = (pi == 0) ? 299 : 700;
          case (di)
            0: duty = 0;
            1: duty = 1;
            2: duty = 150;
            3: duty = 256;
            4: duty = per;
            5: duty = per + 1;
            default: duty = per + 50;
          endcase
          setup(1, ps, per % 256, per / 256, duty % 256, duty / 256);
          win = (per + 1) * (ps + 1);
          repeat (4) @(negedge clk);
          measure(win, h0, h1);
          chk($sformatf("R5 ps=%0d per=%0d duty=%0d", ps, per, duty), h0,
              mn(duty, per + 1) * (ps + 1));
          chk("R5 out1 low", h1, 0);
        end

    // R6: duty update held until the period boundary
    setup(0, 0, 99, 0, 20, 0);
    t1 = 0;
    do begin
      @(negedge clk); t1++;
    end while (!(pwm_o[0] == 1'b0 && u_prev_hi) && t1 < 500);
    wr(4, 80);
    measure(40, h0, h1);
    chk("R6 old duty kept", h0, 0);
    repeat (100) @(negedge clk);
    measure(100, h0, h1);
    chk("R6 new duty applied", h0, 80);

    // R7: capture edges ignored outside capture mode
    cap_i = 2'b10;
    repeat (10) @(negedge clk);
    cap_i = 2'b01;
    repeat (10) @(negedge clk);
    cap_i = 2'b10;
    repeat (6) @(negedge clk);
    rd(10, v);
    chk("R7 no capture in pwm mode", v, 0);

    // R10 R7: mode change restarts count; exact capture value
    wr(0, 3); wr(1, 0);
    wr(0, 4'b1010);
    chk("R10 pwm cleared", int'(pwm_o), 0);
    repeat (5) @(negedge clk);
    cap_i[0] = 1'b1;
    repeat (6) @(negedge clk);
    rd16(6, v);
    chk("R10 R7 capture after mode change", v, 7);
    rd(10, v);
    chk("R7 status flag0", v, 1);
    chk("R7 irq0", int'(irq_o), 1);

    // R7 falling edge on ch1, interval 300 crosses byte carry
    cap_i[1] = 1'b0; c1 = cyc;
    repeat (6) @(negedge clk);
    rd16(8, v); t1 = v;
    wr(10, 2);
    cap_i[1] = 1'b1;
    while (cyc < c1 + 300) @(negedge clk);
    cap_i[1] = 1'b0; c2 = cyc;
    repeat (6) @(negedge clk);
    rd16(8, v);
    chk("R7 ch1 interval", (v - t1) & 16'hFFFF, c2 - c1);
    rd(10, v);
    chk("R7 status flags", v & 3, 3);

    // R8: second ch0 capture with flag still set
    cap_i[0] = 1'b0;
    repeat (6) @(negedge clk);
    cap_i[0] = 1'b1;
    repeat (6) @(negedge clk);
    rd(10, v);
    chk("R8 overrun ch0", (v >> 2) & 1, 1);
    chk("R8 no overrun ch1", (v >> 3) & 1, 0);

    // R9: write-one-to-clear, zero leaves bits
    wr(10, 4'b0100);
    rd(10, v);
    chk("R9 partial clear", v, 3);
    wr(10, 4'b1111);
    rd(10, v);
    chk("R9 full clear", v, 0);
    chk("R9 irq cleared", int'(irq_o), 0);

    // R2: prescaler 3 in capture mode, 40 clocks -> 10 counts
    wr(0, 3); wr(1, 3); wr(0, 2);
    cap_i[0] = 1'b0;
    repeat (8) @(negedge clk);
    cap_i[0] = 1'b1; c1 = cyc;
    repeat (6) @(negedge clk);
    rd16(6, t1);
    wr(10, 1);
    cap_i[0] = 1'b0;
    while (cyc < c1 + 40) @(negedge clk);
    cap_i[0] = 1'b1;
    repeat (6) @(negedge clk);
    rd16(6, v);
    chk("R2 prescaled interval", v - t1, 10);

    // R10: idle mode holds outputs low
    setup(0, 0, 3, 3, 4, 4);
    repeat (4) @(negedge clk);
    wr(0, 3);
    measure(20, h0, h1);
    chk("R10 idle outputs", h0 + h1, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  logic u_prev_hi = 1'b0;
  always @(negedge clk) u_prev_hi <= pwm_o[0];

  initial begin
    #1_500_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule